// File: doc/BRIEF.md
# Sequential Signed Long Divider

This block divides a signed 32-bit dividend, given as an upper word and a lower word, by a signed 16-bit divisor. It returns a 16-bit quotient, a 16-bit remainder and an overflow flag. It works on operand magnitudes with a restoring shift-subtract loop that resolves one quotient bit per clock. A final cycle then applies the signs.

A caller pulses `start` with the operands valid while `busy` is low. The block captures the operands on that edge and raises `busy`. It ends with a one-cycle `done` pulse, and its result outputs stay unchanged until the next accepted division completes.

When the upper word of the dividend magnitude is not smaller than the divisor magnitude, the quotient cannot fit, and a divisor of zero always falls in this case. The block then skips the loop, flags overflow and hands back the original dividend words. A quotient can also come out with the wrong sign after sign correction, and the block flags overflow in that case too.

Top module: `sdiv_top`

## Requirements
- R1: After reset, `busy`, `done`, `ovf`, `quo_out` and `rem_out` are all zero.
- R2: A negative dividend (bit 15 of `dvd_hi` set) is two's-complement negated as a full 32-bit value before dividing. A negative divisor (bit 15 set) is negated to its magnitude.
- R3: If the upper word of the dividend magnitude is greater than or equal to the divisor magnitude, no division takes place. This includes a divisor of zero. `ovf` is then 1, `quo_out` returns the original `dvd_lo` and `rem_out` returns the original `dvd_hi`.
- R4: Otherwise `quo_out` is the quotient of the magnitudes and `rem_out` is the remainder, and `ovf` is 0 unless R6 applies.
- R5: The quotient sign is the XOR of the dividend and divisor sign bits. A nonzero quotient is negated when that sign is 1, and a zero quotient is never negated.
- R6: A nonzero quotient whose bit 15 after sign correction differs from the quotient sign sets `ovf`.
- R7: The remainder is negated when the dividend was negative, so a nonzero remainder carries the dividend's sign.
- R8: An accepted start raises `busy` on the next cycle. `done` is a single-cycle pulse with `busy` low. The overflow path finishes 1 cycle after the start edge and the division path finishes 18 cycles after it (1 setup cycle, 16 loop cycles, 1 sign cycle).
- R9: `start` is ignored while `busy` is high, and the operands on the ports at that time have no effect on the result.
- R10: `quo_out`, `rem_out` and `ovf` change only on the cycle `done` rises. They hold the previous result while a new division runs and after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| dvd_hi | input | 16 | Dividend upper word |
| dvd_lo | input | 16 | Dividend lower word |
| dvs | input | 16 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quo_out | output | 16 | Quotient, or original lower word on early overflow |
| rem_out | output | 16 | Remainder, or original upper word on early overflow |
| ovf | output | 1 | Overflow flag |

## Verification
Results are due exactly 18 clock edges after the edge that accepts `start` when a division runs, and 1 edge after it when early overflow stops the run. Each bench task drives inputs on the falling edge and counts falling edges until `done` appears. It checks that the count matches the path the reference model predicts, and it samples the outputs in that same half-cycle. The hold and ignore checks read the outputs at falling edges while a later run is still busy, which is before the next `done` can legally change them.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2,
        ST_FIX   = 2'd3
    } sdiv_state_e;

    typedef struct packed {
        logic quo_neg;
        logic rem_neg;
    } sdiv_sign_t;

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep
    import sdiv_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] dv,
    output logic [W-1:0] mag_hi,
    output logic [W-1:0] mag_lo,
    output logic [W:0]   dv_mag,
    output sdiv_sign_t   signs,
    output logic         early_ovf
);
    localparam int DW = 2 * W;

    logic [DW-1:0] full;
    logic [DW-1:0] full_mag;

    always_comb begin
        full     = {hi, lo};
        full_mag = hi[W-1] ? (~full + DW'(1)) : full;
        mag_hi   = full_mag[DW-1:W];
        mag_lo   = full_mag[W-1:0];
        dv_mag   = dv[W-1] ? ({1'b0, ~dv} + (W+1)'(1)) : {1'b0, dv};
        signs.rem_neg = hi[W-1];
        signs.quo_neg = hi[W-1] ^ dv[W-1];
        early_ovf = ({1'b0, mag_hi} >= dv_mag);
    end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core
    import sdiv_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] rem_init,
    input  logic [W-1:0] quo_init,
    input  logic [W:0]   dv_mag,
    output logic [W-1:0] rem,
    output logic [W-1:0] quo
);
    logic [W+1:0] trial;

    always_comb begin
        trial = {1'b0, rem, quo[W-1]} - {1'b0, dv_mag};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            quo <= '0;
        end else if (load) begin
            rem <= rem_init;
            quo <= quo_init;
        end else if (step) begin
            if (!trial[W+1]) begin
                rem <= trial[W-1:0];
                quo <= {quo[W-2:0], 1'b1};
            end else begin
                rem <= {rem[W-2:0], quo[W-1]};
                quo <= {quo[W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix
    import sdiv_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  sdiv_sign_t   signs,
    output logic [W-1:0] quo_s,
    output logic [W-1:0] rem_s,
    output logic         late_ovf
);
    logic nz;

    always_comb begin
        nz       = (quo_mag != '0);
        quo_s    = (nz && signs.quo_neg) ? (~quo_mag + W'(1)) : quo_mag;
        late_ovf = nz && (quo_s[W-1] != signs.quo_neg);
        rem_s    = signs.rem_neg ? (~rem_mag + W'(1)) : rem_mag;
    end
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
    import sdiv_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvs,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out,
    output logic         ovf
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sdiv_state_e   state;
    logic [CW-1:0] iter;
    logic [W-1:0]  cap_hi, cap_lo, cap_dv;

    logic [W-1:0]  mag_hi, mag_lo, c_rem, c_quo, f_quo, f_rem;
    logic [W:0]    dv_mag;
    sdiv_sign_t    signs;
    logic          early_ovf, late_ovf;

    sdiv_prep #(.W(W)) u_prep (
        .hi(cap_hi), .lo(cap_lo), .dv(cap_dv),
        .mag_hi(mag_hi), .mag_lo(mag_lo), .dv_mag(dv_mag),
        .signs(signs), .early_ovf(early_ovf)
    );

    sdiv_core #(.W(W)) u_core (
        .clk(clk), .rst(rst),
        .load(state == ST_SETUP), .step(state == ST_RUN),
        .rem_init(mag_hi), .quo_init(mag_lo), .dv_mag(dv_mag),
        .rem(c_rem), .quo(c_quo)
    );

    sdiv_fix #(.W(W)) u_fix (
        .quo_mag(c_quo), .rem_mag(c_rem), .signs(signs),
        .quo_s(f_quo), .rem_s(f_rem), .late_ovf(late_ovf)
    );

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            iter    <= '0;
            cap_hi  <= '0;
            cap_lo  <= '0;
            cap_dv  <= '0;
            quo_out <= '0;
            rem_out <= '0;
            ovf     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cap_hi <= dvd_hi;
                        cap_lo <= dvd_lo;
                        cap_dv <= dvs;
                        state  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    iter <= '0;
                    if (early_ovf) begin
                        quo_out <= cap_lo;
                        rem_out <= cap_hi;
                        ovf     <= 1'b1;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    iter <= iter + CW'(1);
                    if (iter == LAST) state <= ST_FIX;
                end
                ST_FIX: begin
                    quo_out <= f_quo;
                    rem_out <= f_rem;
                    ovf     <= late_ovf;
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] dvd_hi,
    input logic [W-1:0] dvd_lo,
    input logic [W-1:0] dvs,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quo_out,
    input logic [W-1:0] rem_out,
    input logic         ovf
);
    localparam int FULL_LAT = W + 2;

    logic [W-1:0] k_hi, k_lo, k_dv;
    logic [7:0]   busy_cnt;
    logic         past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            k_hi <= '0; k_lo <= '0; k_dv <= '0;
            busy_cnt <= '0;
            past_ok  <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (start && !busy) begin
                k_hi <= dvd_hi; k_lo <= dvd_lo; k_dv <= dvs;
            end
            busy_cnt <= busy ? busy_cnt + 8'd1 : 8'd0;
        end
    end

    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == 8'd1 || busy_cnt == 8'(FULL_LAT)));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !done) |-> ($stable(quo_out) && $stable(rem_out) && $stable(ovf)));

    p_zero_div_r3: assert property (@(posedge clk) disable iff (rst)
        (done && k_dv == '0) |-> (ovf && quo_out == k_lo && rem_out == k_hi));

    p_rem_sign_r7: assert property (@(posedge clk) disable iff (rst)
        (done && busy_cnt == 8'(FULL_LAT) && rem_out != '0) |-> (rem_out[W-1] == k_hi[W-1]));
endmodule

bind sdiv_top sdiv_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
    .busy(busy), .done(done),
    .quo_out(quo_out), .rem_out(rem_out), .ovf(ovf)
);

// File: tb/tb_sdiv_top.sv
module tb_sdiv_top;
    localparam int  W      = 16;
    localparam time CLK_P  = 10ns;
    localparam int  WD_MAX = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
    logic         busy, done, ovf;
    logic [W-1:0] quo_out, rem_out;

    int checks = 0;
    int bad    = 0;
    int cyc    = 0;

    sdiv_top dut (
        .clk(clk), .rst(rst), .start(start),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
        .busy(busy), .done(done),
        .quo_out(quo_out), .rem_out(rem_out), .ovf(ovf)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_MAX) begin
            bad = bad + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_MAX);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model built from R2..R7
    task automatic ref_div(input logic [W-1:0] hi, input logic [W-1:0] lo,
                           input logic [W-1:0] dv,
                           output logic [W-1:0] q, output logic [W-1:0] r,
                           output logic o, output int lat);
        longint dd, dm, vm, qq, rr;
        logic rs, qs;
        dd = longint'($signed({hi, lo}));
        rs = hi[W-1];
        qs = hi[W-1] ^ dv[W-1];
        dm = (dd < 0) ? -dd : dd;
        vm = longint'($signed(dv));
        if (vm < 0) vm = -vm;
        if ((dm >> W) >= vm) begin
            q = lo; r = hi; o = 1'b1; lat = 2;
        end else begin
            qq = dm / vm;
            rr = dm % vm;
            q = W'(qq);
            o = 1'b0;
            if (q != '0) begin
                if (qs) q = ~q + W'(1);
                o = (q[W-1] != qs);
            end
            r = W'(rr);
            if (rs) r = ~r + W'(1);
            lat = W + 3;
        end
    endtask

    // Start a division; latency counted in falling edges after driving start
    task automatic launch(input logic [W-1:0] hi, input logic [W-1:0] lo,
                          input logic [W-1:0] dv);
        @(negedge clk);
        dvd_hi = hi; dvd_lo = lo; dvs = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_div(input string tag, input logic [W-1:0] hi,
                           input logic [W-1:0] lo, input logic [W-1:0] dv);
        logic [W-1:0] eq, er;
        logic eo;
        int el, n;
        ref_div(hi, lo, dv, eq, er, eo, el);
        launch(hi, lo, dv);
        n = 1;
        chk({tag, " R8 busy after accept"}, longint'(busy || done), 1);
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R8 latency"}, n, el);
        chk({tag, " quotient R4/R5"}, quo_out, eq);
        chk({tag, " remainder R4/R7"}, rem_out, er);
        chk({tag, " overflow R3/R6"}, ovf, eo);
        @(negedge clk);
        chk({tag, " R8 done pulse"}, done, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 quo", quo_out, 0);
        chk("R1 rem", rem_out, 0);
    endtask

    task automatic t_corners();
        run_div("R2 most-negative by 1", 16'h8000, 16'h0000, 16'h0001);
        run_div("R3 most-negative by -1", 16'h8000, 16'h0000, 16'hFFFF);
        run_div("R3 zero divisor", 16'h1234, 16'h5678, 16'h0000);
        run_div("R3 zero/zero", 16'h0000, 16'h0000, 16'h0000);
        run_div("R4 exact 100/-5", 16'h0000, 16'd100, 16'hFFFB);
        run_div("R5 exact -100/-5", 16'hFFFF, 16'hFF9C, 16'hFFFB);
        run_div("R7 -7/2", 16'hFFFF, 16'hFFF9, 16'h0002);
        run_div("R6 32768/1", 16'h0000, 16'h8000, 16'h0001);
        run_div("R6 -32768/1 fits", 16'hFFFF, 16'h8000, 16'h0001);
        run_div("R5 zero quotient", 16'hFFFF, 16'hFFFD, 16'h0007);
        run_div("R2 divisor -32768", 16'h3FFF, 16'hFFFF, 16'h8000);
        run_div("R3 hi equals divisor", 16'h0005, 16'h0000, 16'h0005);
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] h, l, d;
            h = W'($urandom);
            l = W'($urandom);
            d = W'($urandom);
            if (i % 2 == 0) h = {{(W/2+1){h[W-1]}}, h[W/2-2:0]};
            run_div("R4 random", h, l, d);
        end
    endtask

    task automatic t_ignore_hold();
        logic [W-1:0] pq, pr, eq, er;
        logic po, eo;
        int el;
        run_div("R10 first", 16'h0001, 16'h0000, 16'h0003);
        pq = quo_out; pr = rem_out; po = ovf;
        ref_div(16'h0000, 16'h0400, 16'hFFFC, eq, er, eo, el);
        launch(16'h0000, 16'h0400, 16'hFFFC);
        repeat (3) @(negedge clk);
        dvd_hi = 16'h7FFF; dvd_lo = 16'h1111; dvs = 16'h0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 hold quo during run", quo_out, pq);
        chk("R10 hold rem during run", rem_out, pr);
        chk("R10 hold ovf during run", ovf, po);
        for (int n = 0; n < 100 && !done; n++) @(negedge clk);
        chk("R9 quo ignores late start", quo_out, eq);
        chk("R9 rem ignores late start", rem_out, er);
        chk("R9 ovf ignores late start", ovf, eo);
        repeat (5) @(negedge clk);
        chk("R9 no second run", busy, 0);
        chk("R10 hold quo after done", quo_out, eq);
        chk("R10 hold rem after done", rem_out, er);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_corners();
        t_random();
        t_ignore_hold();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule